// File: doc/BRIEF.md
# Interrupt and Halt Controller

This block sits next to an 8-bit CPU core. It owns the master interrupt enable and decides, at each instruction boundary, whether the core keeps running, stays parked in a low-power halt, or branches to an interrupt handler. The core supplies its enable and request registers (five sources, bit 0 = vertical blank, 1 = LCD status, 2 = timer, 3 = serial, 4 = joypad), a one-cycle strobe for each of the enable-interrupts, disable-interrupts and halt instructions as they are decoded, and a strobe that marks the end of every instruction.

The block answers with a halted level that stalls the core, a one-cycle dispatch request carrying the winning source index and its handler address, a one-hot pulse that tells the request register which bit to clear, and a level that tells the core not to advance its program counter on the next fetch. That last level covers the case where halt is executed with interrupts masked while a request is already waiting: the core does not halt, and the byte after the halt runs twice. The core's own stack pushes and program counter updates are outside this block.

Top module: `irqHaltCtrl`

## Requirements
- R1: After reset the master enable, halted, dispatch request, flag-clear pulse and PC-hold outputs are all 0.
- R2: An enable strobe leaves `imeOut` at 0 until the next boundary strobe; `imeOut` reads 1 in the cycle after that boundary.
- R3: A disable strobe drives `imeOut` to 0 in the next cycle and cancels an enable that is still queued, so a later boundary does not set the enable.
- R4: A dispatch request appears only in the cycle after a boundary at which the master enable was already 1 and at least one source was pending; no boundary, or a clear enable, gives no dispatch.
- R5: Among pending sources the lowest bit index wins; `dispatchIdx` carries that index and `vectorAddr` equals 0x40 + 8 × index.
- R6: With the dispatch request, `flagClear` is one-hot on the winning bit, `imeOut` is 0, and all three return to 0 one cycle later.
- R7: A halt strobe when the enable is 1 or when nothing is pending makes `halted` 1 in the next cycle.
- R8: `halted` stays 1 through boundaries with nothing pending and through cycles without a boundary; it drops in the cycle after a boundary with a pending source, even if the enable is 0.
- R9: A halt strobe with the enable 0 and a source pending leaves `halted` at 0 and raises `pcHold` in the next cycle; `pcHold` stays 1 until the cycle after the next boundary.
- R10: The boundary that turns a queued enable into an active one does not itself dispatch; a pending source is taken at the following boundary.
- R11: A source counts as pending only when its enable bit and its request bit are both 1; a set enable bit with a clear request bit, or the reverse, neither dispatches nor wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ieReg | input | 5 | Per-source enable bits from the core |
| ifReg | input | 5 | Per-source request bits from the core |
| eiStrobe | input | 1 | Enable-interrupts instruction decoded |
| diStrobe | input | 1 | Disable-interrupts instruction decoded |
| haltStrobe | input | 1 | Halt instruction decoded |
| boundary | input | 1 | One instruction has finished |
| imeOut | output | 1 | Current master interrupt enable |
| halted | output | 1 | Core is parked; stall at boundaries |
| dispatchReq | output | 1 | One-cycle request to enter a handler |
| dispatchIdx | output | 3 | Index of the source being taken |
| vectorAddr | output | 8 | Handler address for that source |
| flagClear | output | 5 | One-hot pulse clearing the taken request bit |
| pcHold | output | 1 | Next fetch must not advance the program counter |

## Verification
On every cycle the assertions check that a dispatch follows only an enabled boundary with a pending source, that it clears the enable and pulses exactly one pending bit, that halt is entered only from a halt strobe and left only at a pending boundary, that a disable always wins, and that the PC-hold and halted levels never coexist. The priority order and handler addresses, the one-instruction delay of the enable, the cancellation of a queued enable, and the timing of the double-fetch window can only be shown by the bench's scenarios, which compare exact values in fixed cycles.

// File: rtl/irqHaltPkg.sv
package irqHaltPkg;

  // Decisions made by the control module for one clock cycle.
  typedef struct packed {
    logic queueEi;    // remember an enable for the next boundary
    logic promoteEi;  // queued enable becomes active
    logic dropIme;    // disable instruction
    logic enterHalt;  // park the core
    logic armBug;     // masked halt with a pending source
    logic leaveHalt;  // wake from the parked state
    logic takeIrq;    // enter a handler
    logic clearBug;   // double-fetch window consumed
  } ctlStrobes_t;

endpackage

// File: rtl/irqPrioPick.sv
module irqPrioPick #(
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] grant,
  output logic [IDX_W-1:0]   grantIdx
);

  // Lowest index wins: a bit is granted only if no lower bit is pending.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gen_grant
    if (g == 0) begin : gen_first
      assign grant[g] = pend[g];
    end else begin : gen_rest
      assign grant[g] = pend[g] & ~(|pend[g-1:0]);
    end
  end

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) grantIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irqHaltCtl.sv
module irqHaltCtl
  import irqHaltPkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] ieReg,
  input  logic [NUM_SRC-1:0] ifReg,
  input  logic               eiStrobe,
  input  logic               diStrobe,
  input  logic               haltStrobe,
  input  logic               boundary,
  input  logic               imeQ,
  input  logic               eiPendQ,
  input  logic               haltedQ,
  input  logic               bugQ,
  output logic [NUM_SRC-1:0] pendVec,
  output ctlStrobes_t        strobes
);

  logic anyPend;

  assign pendVec = ieReg & ifReg;
  assign anyPend = |pendVec;

  always_comb begin
    strobes           = '0;
    strobes.queueEi   = eiStrobe && !diStrobe;
    strobes.dropIme   = diStrobe;
    strobes.promoteEi = boundary && eiPendQ;
    // Dispatch uses the enable as it stood before this boundary's promotion.
    strobes.takeIrq   = boundary && imeQ && anyPend;
    strobes.leaveHalt = boundary && haltedQ && anyPend;
    strobes.clearBug  = boundary && bugQ;
    strobes.armBug    = haltStrobe && !imeQ && anyPend;
    strobes.enterHalt = haltStrobe && !(!imeQ && anyPend);
  end

endmodule

// File: rtl/irqHaltDp.sv
module irqHaltDp
  import irqHaltPkg::*;
#(
  parameter int                 NUM_SRC  = 5,
  parameter int                 IDX_W    = 3,
  parameter int                 VEC_W    = 8,
  parameter logic [VEC_W-1:0]   VEC_BASE = 8'h40,
  parameter int                 VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] pendVec,
  output logic               imeQ,
  output logic               eiPendQ,
  output logic               haltedQ,
  output logic               bugQ,
  output logic               reqQ,
  output logic [IDX_W-1:0]   idxQ,
  output logic [VEC_W-1:0]   vecQ,
  output logic [NUM_SRC-1:0] clrQ
);

  logic [NUM_SRC-1:0] grant;
  logic [IDX_W-1:0]   winIdx;

  irqPrioPick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_pick (
    .pend    (pendVec),
    .grant   (grant),
    .grantIdx(winIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imeQ    <= 1'b0;
      eiPendQ <= 1'b0;
      haltedQ <= 1'b0;
      bugQ    <= 1'b0;
      reqQ    <= 1'b0;
      idxQ    <= '0;
      vecQ    <= '0;
      clrQ    <= '0;
    end else begin
      reqQ <= strobes.takeIrq;
      clrQ <= strobes.takeIrq ? grant : '0;
      if (strobes.takeIrq) begin
        idxQ <= winIdx;
        vecQ <= VEC_BASE + VEC_W'(winIdx) * VEC_W'(VEC_STEP);
      end

      // Disable and dispatch both win over a promotion in the same cycle.
      if (strobes.dropIme || strobes.takeIrq)  imeQ <= 1'b0;
      else if (strobes.promoteEi)              imeQ <= 1'b1;

      if (strobes.dropIme || strobes.takeIrq)  eiPendQ <= 1'b0;
      else if (strobes.queueEi)                eiPendQ <= 1'b1;
      else if (strobes.promoteEi)              eiPendQ <= 1'b0;

      if (strobes.enterHalt)                   haltedQ <= 1'b1;
      else if (strobes.leaveHalt)              haltedQ <= 1'b0;

      if (strobes.armBug)                      bugQ <= 1'b1;
      else if (strobes.clearBug)               bugQ <= 1'b0;
    end
  end

  // A disable leaves neither an active nor a queued enable behind.
  assert_di_cancels_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dropIme |=> (!imeQ && !eiPendQ));

  // The double-fetch window and the parked state exclude each other.
  assert_bug_not_halted_R9: assert property (@(posedge clk) disable iff (!rstN)
    bugQ |-> !haltedQ);

  // A granted clear targets a bit that was pending when the dispatch was decided.
  assert_clear_was_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |-> ((clrQ & ~$past(pendVec)) == '0));

endmodule

// File: rtl/irqHaltCtrl.sv
module irqHaltCtrl
  import irqHaltPkg::*;
#(
  parameter int               NUM_SRC  = 5,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
  parameter int               VEC_STEP = 8,
  localparam int              IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] ieReg,
  input  logic [NUM_SRC-1:0] ifReg,
  input  logic               eiStrobe,
  input  logic               diStrobe,
  input  logic               haltStrobe,
  input  logic               boundary,
  output logic               imeOut,
  output logic               halted,
  output logic               dispatchReq,
  output logic [IDX_W-1:0]   dispatchIdx,
  output logic [VEC_W-1:0]   vectorAddr,
  output logic [NUM_SRC-1:0] flagClear,
  output logic               pcHold
);

  ctlStrobes_t        strobes;
  logic [NUM_SRC-1:0] pendVec;
  logic               imeQ, eiPendQ, haltedQ, bugQ;

  irqHaltCtl #(.NUM_SRC(NUM_SRC)) i_ctl (
    .ieReg     (ieReg),
    .ifReg     (ifReg),
    .eiStrobe  (eiStrobe),
    .diStrobe  (diStrobe),
    .haltStrobe(haltStrobe),
    .boundary  (boundary),
    .imeQ      (imeQ),
    .eiPendQ   (eiPendQ),
    .haltedQ   (haltedQ),
    .bugQ      (bugQ),
    .pendVec   (pendVec),
    .strobes   (strobes)
  );

  irqHaltDp #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .pendVec(pendVec),
    .imeQ   (imeQ),
    .eiPendQ(eiPendQ),
    .haltedQ(haltedQ),
    .bugQ   (bugQ),
    .reqQ   (dispatchReq),
    .idxQ   (dispatchIdx),
    .vecQ   (vectorAddr),
    .clrQ   (flagClear)
  );

  assign imeOut = imeQ;
  assign halted = haltedQ;
  assign pcHold = bugQ;

  assert_req_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReq |-> ($past(boundary) && $past(imeOut) && (|$past(ieReg & ifReg))));

  assert_req_effects_R6: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReq |-> (!imeOut && ($countones(flagClear) == 1)));

  assert_enable_at_boundary_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(imeOut) |-> $past(boundary));

  assert_halt_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> $past(haltStrobe));

  assert_halt_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halted) |-> ($past(boundary) && (|$past(ieReg & ifReg))));

  assert_no_clear_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !dispatchReq |-> (flagClear == '0));

endmodule

// File: tb/test_irqHaltCtrl.sv
`timescale 1ns/1ps
module test_irqHaltCtrl;

  localparam int NUM_SRC  = 5;
  localparam int WATCHDOG = 100000;

  // Row layout: [20:16] enable, [15:11] request, [10:8] index, [7:0] handler address
  localparam logic [20:0] VEC_TABLE [8] = '{
    {5'h1f, 5'h1f, 3'd0, 8'h40},
    {5'h1e, 5'h1f, 3'd1, 8'h48},
    {5'h1f, 5'h1c, 3'd2, 8'h50},
    {5'h08, 5'h0f, 3'd3, 8'h58},
    {5'h10, 5'h1f, 3'd4, 8'h60},
    {5'h0a, 5'h06, 3'd1, 8'h48},
    {5'h14, 5'h1c, 3'd2, 8'h50},
    {5'h18, 5'h10, 3'd4, 8'h60}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] ieReg = '0;
  logic [NUM_SRC-1:0] ifReg = '0;
  logic               eiStrobe = 1'b0;
  logic               diStrobe = 1'b0;
  logic               haltStrobe = 1'b0;
  logic               boundary = 1'b0;
  logic               imeOut, halted, dispatchReq, pcHold;
  logic [2:0]         dispatchIdx;
  logic [7:0]         vectorAddr;
  logic [NUM_SRC-1:0] flagClear;

  int  compared   = 0;
  int  mismatched = 0;
  bit  done       = 1'b0;

  always #4 clk = ~clk;

  irqHaltCtrl i_irqHaltCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ieReg      (ieReg),
    .ifReg      (ifReg),
    .eiStrobe   (eiStrobe),
    .diStrobe   (diStrobe),
    .haltStrobe (haltStrobe),
    .boundary   (boundary),
    .imeOut     (imeOut),
    .halted     (halted),
    .dispatchReq(dispatchReq),
    .dispatchIdx(dispatchIdx),
    .vectorAddr (vectorAddr),
    .flagClear  (flagClear),
    .pcHold     (pcHold)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Each task starts and ends just after a falling edge; outputs then show the
  // rising edge that saw the strobe.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic pulseBoundary();
    boundary = 1'b1; @(negedge clk); boundary = 1'b0;
  endtask
  task automatic pulseEi();
    eiStrobe = 1'b1; @(negedge clk); eiStrobe = 1'b0;
  endtask
  task automatic pulseDi();
    diStrobe = 1'b1; @(negedge clk); diStrobe = 1'b0;
  endtask
  task automatic pulseHalt();
    haltStrobe = 1'b1; @(negedge clk); haltStrobe = 1'b0;
  endtask
  task automatic enableNow();
    logic [NUM_SRC-1:0] saveIe;
    saveIe = ieReg; ieReg = '0;
    pulseEi(); pulseBoundary();
    ieReg = saveIe;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 imeOut", imeOut, 0);
    check("R1 halted", halted, 0);
    check("R1 dispatchReq", dispatchReq, 0);
    check("R1 pcHold", pcHold, 0);
    check("R1 flagClear", flagClear, 0);
    rstN = 1'b1;
    idle(1);

    // R5 / R6: priority and handler address over the vector table
    foreach (VEC_TABLE[k]) begin
      ieReg = '0; ifReg = '0;
      pulseEi();
      check("R2 not yet enabled", imeOut, 0);
      pulseBoundary();
      check("R2 enabled after boundary", imeOut, 1);
      ieReg = VEC_TABLE[k][20:16];
      ifReg = VEC_TABLE[k][15:11];
      pulseBoundary();
      check("R4 dispatch taken", dispatchReq, 1);
      check("R5 index", dispatchIdx, VEC_TABLE[k][10:8]);
      check("R5 vector", vectorAddr, VEC_TABLE[k][7:0]);
      check("R6 clear bit", flagClear, 1 << VEC_TABLE[k][10:8]);
      check("R6 enable cleared", imeOut, 0);
      ieReg = '0; ifReg = '0;
      idle(1);
      check("R6 request one cycle", dispatchReq, 0);
      check("R6 clear one cycle", flagClear, 0);
    end

    // R10: the promoting boundary does not dispatch
    ieReg = 5'h01; ifReg = 5'h01;
    pulseEi();
    pulseBoundary();
    check("R10 no dispatch on promote", dispatchReq, 0);
    check("R10 enable now set", imeOut, 1);
    pulseBoundary();
    check("R10 dispatch next boundary", dispatchReq, 1);
    check("R10 index", dispatchIdx, 0);
    ieReg = '0; ifReg = '0;

    // R3: disable cancels a queued enable and clears an active one
    pulseEi();
    pulseDi();
    check("R3 enable stays clear", imeOut, 0);
    pulseBoundary();
    check("R3 queued enable cancelled", imeOut, 0);
    enableNow();
    check("R3 setup enabled", imeOut, 1);
    pulseDi();
    check("R3 disable immediate", imeOut, 0);

    // R4: no dispatch with the enable clear, or without a boundary
    ieReg = 5'h04; ifReg = 5'h04;
    pulseBoundary();
    check("R4 masked no dispatch", dispatchReq, 0);
    enableNow();
    begin
      int seen = 0;
      for (int i = 0; i < 4; i++) begin
        idle(1);
        if (dispatchReq) seen++;
      end
      check("R4 no boundary no dispatch", seen, 0);
    end
    pulseBoundary();
    check("R4 boundary dispatch", dispatchReq, 1);
    check("R4 index", dispatchIdx, 2);

    // R11: enable and request must both be set
    ieReg = '0; ifReg = '0;
    enableNow();
    ieReg = 5'h1f; ifReg = 5'h00;
    pulseBoundary();
    check("R11 enabled only", dispatchReq, 0);
    ieReg = 5'h00; ifReg = 5'h1f;
    pulseBoundary();
    check("R11 requested only", dispatchReq, 0);
    check("R11 enable kept", imeOut, 1);
    pulseDi();
    ieReg = '0; ifReg = '0;

    // R7 / R8: halt with nothing pending, wake with enable clear
    pulseHalt();
    check("R7 halted", halted, 1);
    check("R7 no pcHold", pcHold, 0);
    ieReg = 5'h01;
    pulseBoundary();
    pulseBoundary();
    check("R11 enable without request keeps halt", halted, 1);
    ifReg = 5'h01;
    idle(2);
    check("R8 waits for boundary", halted, 1);
    pulseBoundary();
    check("R8 woken while masked", halted, 0);
    check("R8 no dispatch while masked", dispatchReq, 0);
    ieReg = '0; ifReg = '0;

    // R7 / R8: halt with enable set, wake then dispatch
    enableNow();
    ieReg = 5'h08; ifReg = 5'h08;
    pulseHalt();
    check("R7 halted with enable", halted, 1);
    pulseBoundary();
    check("R8 woken", halted, 0);
    check("R8 dispatch on wake", dispatchReq, 1);
    check("R8 wake index", dispatchIdx, 3);
    ieReg = '0; ifReg = '0;

    // R9: masked halt with a pending source
    ieReg = 5'h02; ifReg = 5'h02;
    pulseHalt();
    check("R9 not halted", halted, 0);
    check("R9 pcHold raised", pcHold, 1);
    idle(2);
    check("R9 pcHold held", pcHold, 1);
    pulseBoundary();
    check("R9 pcHold released", pcHold, 0);
    check("R9 still running", halted, 0);
    ieReg = '0; ifReg = '0;

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule